// File: doc/BRIEF.md
# TDM Serial Output Bit Advancer

This block turns per-channel bytes into one time-division-multiplexed serial stream and can launch every bit a few fine clock ticks ahead of its nominal place. All timing is counted on a fast clock of about 262 MHz, so one tick is about 3.8 ns. A frame pulse from outside marks each frame boundary. With no advance, the most significant bit of channel 0 leaves on the boundary itself, and the channels follow in ascending order, MSB first. When an advance is programmed, the whole bit grid moves earlier by a fixed number of ticks. The grid wraps over the frame, so the first bit of the next frame also starts early by the same amount. This lets a board make up for routing delays that differ from one output stream to another.

The advance equals a 2-bit level times a step size. The step depends on where the output timing comes from. With the internal timebase, the step is 2 ticks at the three lower line rates and 1 tick at the highest rate. With an external reference clock, the step is half that clock's period at the two faster reference frequencies. At the two slower reference frequencies the level is ignored. Rate, level and clock source are taken only on a frame boundary. Bytes are fetched one bit time before they are needed, through a request strobe that carries the channel number.

Top module: `tdm_bit_advancer`

## Requirements
- R1: With level 0, bit 7 of channel 0 is on `sdo` from the boundary edge (the edge that samples `frame_pulse` high), and bit n of the frame starts n*B ticks after that edge.
- R2: `rate_sel` 0, 1, 2, 3 select 8, 16, 32, 65 Mbps, and these give bit lengths B of 32, 16, 8, 4 ticks. A frame carries FRAME_TICKS/(8*B) channels in ascending order, MSB first. After reset `sdo` and `data_req` are low.
- R3: With the internal timebase (`ext_clk_sel`=0), the advance A is the level times 2 ticks at rates 0 to 2, and the level times 1 tick at rate 3. Every bit then starts A ticks before its R1 position.
- R4: With `ext_clk_sel`=1, `ref_freq` 3 (65 MHz) gives a step of 2 ticks and `ref_freq` 2 (32 MHz) gives a step of 4 ticks.
- R5: With `ext_clk_sel`=1 and `ref_freq` 0 (8 MHz) or 1 (16 MHz), the level has no effect and A is 0.
- R6: A is capped at B-1 ticks.
- R7: Rate, level and clock source are taken only on the boundary edge. A change made during a frame leaves the timing of that frame unchanged.
- R8: With A > 0, the last bit of the final channel ends A ticks before the next boundary edge. Bit 7 of channel 0 of the next frame starts at that same tick.
- R9: `data_req` is a one-tick pulse in the first tick of the last bit of each channel. `req_chan` then holds the next channel number, wrapping to 0 after the last channel. `ch_data` is taken on the tick after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine timing clock, one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | High for one tick; the edge that samples it is the frame boundary |
| rate_sel | input | 2 | Line rate: 0=8, 1=16, 2=32, 3=65 Mbps |
| adv_code | input | 2 | Advance level 0 to 3 |
| ext_clk_sel | input | 1 | 1 = output timing from external reference |
| ref_freq | input | 2 | Reference frequency: 0=8, 1=16, 2=32, 3=65 MHz |
| ch_data | input | 8 | Byte for the channel in `req_chan` |
| data_req | output | 1 | Byte request strobe |
| req_chan | output | FRAME_TICKS bits log2 minus 5 | Channel whose byte is requested |
| sdo | output | 1 | Serial data out |

## Verification
The hardest situation to reach is the tail of a frame under advance. There the grid has already wrapped into the next frame's channel 0 before the boundary pulse arrives, and that byte must already have been requested. To reach it, each scenario programs its settings, lets one boundary apply them, and then compares every tick of the following frame, including the last A ticks. Those ticks can only be right if the wrap and the early request worked. Changing the level halfway through a checked frame, and combining large external-reference steps with short bits, pushes the design into the R6 cap and the R7 hold.

// File: rtl/tdm_adv_pkg.sv
package tdm_adv_pkg;
  localparam int STEP_STD_TICKS   = 2;
  localparam int STEP_FAST_TICKS  = 1;
  localparam int STEP_REF65_TICKS = 2;
  localparam int STEP_REF32_TICKS = 4;
  localparam int MAX_BIT_SHIFT    = 5;
  localparam int ADV_W            = 4;

  typedef enum logic [1:0] {RATE_8 = 2'd0, RATE_16 = 2'd1, RATE_32 = 2'd2, RATE_65 = 2'd3} rate_e;
  typedef enum logic [1:0] {REF_8 = 2'd0, REF_16 = 2'd1, REF_32 = 2'd2, REF_65 = 2'd3} ref_e;

  typedef struct packed {
    rate_e       rate;
    logic [1:0]  level;
    logic        ext;
    ref_e        refc;
  } adv_cfg_t;

  // log2 of ticks per bit
  function automatic logic [2:0] bit_shift(rate_e r);
    return 3'(MAX_BIT_SHIFT - int'(r));
  endfunction

  function automatic int step_ticks(adv_cfg_t c);
    if (c.ext) begin
      case (c.refc)
        REF_65:  return STEP_REF65_TICKS;
        REF_32:  return STEP_REF32_TICKS;
        default: return 0;
      endcase
    end
    return (c.rate == RATE_65) ? STEP_FAST_TICKS : STEP_STD_TICKS;
  endfunction

  // advance in ticks, capped below one bit time
  function automatic logic [ADV_W-1:0] adv_ticks(adv_cfg_t c);
    int raw;
    int cap;
    raw = int'(c.level) * step_ticks(c);
    cap = (1 << bit_shift(c.rate)) - 1;
    return ADV_W'((raw > cap) ? cap : raw);
  endfunction
endpackage

// File: rtl/tdm_adv_step.sv
module tdm_adv_step
  import tdm_adv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  adv_cfg_t         cfg,
  output logic [ADV_W-1:0] adv,
  output logic [2:0]       shift
);
  always_comb begin
    adv   = adv_ticks(cfg);
    shift = bit_shift(cfg.rate);
  end

  a_r6_adv_below_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(adv) < (32'd1 << shift)));

  a_r5_slow_ref_no_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.ext && (cfg.refc == REF_8 || cfg.refc == REF_16)) |-> (adv == '0));
endmodule

// File: rtl/tdm_adv_timebase.sv
module tdm_adv_timebase
  import tdm_adv_pkg::*;
#(
  parameter int FRAME_TICKS = 32768,
  localparam int TW = $clog2(FRAME_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_pulse,
  input  adv_cfg_t         cfg_in,
  input  logic [ADV_W-1:0] adv,
  output adv_cfg_t         cfg_use,
  output logic [TW-1:0]    pos_nxt
);
  logic [TW-1:0] t_q, t_nxt, pos_q;
  adv_cfg_t      cfg_q;

  always_comb begin
    cfg_use = frame_pulse ? cfg_in : cfg_q;
    t_nxt   = frame_pulse ? '0 : t_q + 1'b1;
    pos_nxt = t_nxt + TW'(adv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q   <= '0;
      cfg_q <= '0;
      pos_q <= '0;
    end else begin
      t_q   <= t_nxt;
      pos_q <= pos_nxt;
      if (frame_pulse) cfg_q <= cfg_in;
    end
  end

  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pulse |=> $stable(cfg_q));

  a_r1_boundary_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && adv == '0) |=> (pos_q == '0));
endmodule

// File: rtl/tdm_adv_serializer.sv
module tdm_adv_serializer #(
  parameter int FRAME_TICKS = 32768,
  localparam int TW  = $clog2(FRAME_TICKS),
  localparam int CHW = TW - 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  pos_nxt,
  input  logic [2:0]     shift,
  input  logic [7:0]     ch_data,
  output logic           sdo,
  output logic           data_req,
  output logic [CHW-1:0] req_chan
);
  logic [TW-1:0] bit_cnt, ch_w, nch_mask, next_ch, cur_ch_q;
  logic [2:0]    bit_in;
  logic [7:0]    cur_byte_q, nxt_byte_q, byte_w;
  logic          load_w, last_q, enter_last;

  always_comb begin
    bit_cnt    = pos_nxt >> shift;
    ch_w       = bit_cnt >> 3;
    bit_in     = bit_cnt[2:0];
    nch_mask   = TW'((FRAME_TICKS >> (32'(shift) + 32'd3)) - 1);
    next_ch    = (ch_w + 1'b1) & nch_mask;
    load_w     = (ch_w != cur_ch_q);
    byte_w     = load_w ? nxt_byte_q : cur_byte_q;
    enter_last = (bit_in == 3'd7) && !last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo        <= 1'b0;
      data_req   <= 1'b0;
      req_chan   <= '0;
      cur_ch_q   <= '0;
      cur_byte_q <= '0;
      nxt_byte_q <= '0;
      last_q     <= 1'b0;
    end else begin
      sdo      <= byte_w[3'd7 - bit_in];
      last_q   <= (bit_in == 3'd7);
      data_req <= enter_last;
      if (enter_last) req_chan <= CHW'(next_ch);
      if (data_req) nxt_byte_q <= ch_data;
      if (load_w) begin
        cur_byte_q <= nxt_byte_q;
        cur_ch_q   <= ch_w;
      end
    end
  end

  a_r9_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |=> !data_req);

  a_r2_chan_order: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && ch_w != '0) |-> (ch_w == cur_ch_q + 1'b1));
endmodule

// File: rtl/tdm_bit_advancer.sv
module tdm_bit_advancer
  import tdm_adv_pkg::*;
#(
  parameter int FRAME_TICKS = 32768,
  localparam int TW  = $clog2(FRAME_TICKS),
  localparam int CHW = TW - 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_pulse,
  input  logic [1:0]     rate_sel,
  input  logic [1:0]     adv_code,
  input  logic           ext_clk_sel,
  input  logic [1:0]     ref_freq,
  input  logic [7:0]     ch_data,
  output logic           data_req,
  output logic [CHW-1:0] req_chan,
  output logic           sdo
);
  adv_cfg_t         cfg_in, cfg_use;
  logic [ADV_W-1:0] adv;
  logic [2:0]       shift;
  logic [TW-1:0]    pos_nxt;

  always_comb begin
    cfg_in.rate  = rate_e'(rate_sel);
    cfg_in.level = adv_code;
    cfg_in.ext   = ext_clk_sel;
    cfg_in.refc  = ref_e'(ref_freq);
  end

  tdm_adv_step u_step (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_use), .adv(adv), .shift(shift)
  );

  tdm_adv_timebase #(.FRAME_TICKS(FRAME_TICKS)) u_timebase (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .cfg_in(cfg_in),
    .adv(adv), .cfg_use(cfg_use), .pos_nxt(pos_nxt)
  );

  tdm_adv_serializer #(.FRAME_TICKS(FRAME_TICKS)) u_ser (
    .clk(clk), .rst_n(rst_n), .pos_nxt(pos_nxt), .shift(shift),
    .ch_data(ch_data), .sdo(sdo), .data_req(data_req), .req_chan(req_chan)
  );
endmodule

// File: tb/test_tdm_bit_advancer.sv
module test_tdm_bit_advancer;
  localparam int CLK_PERIOD = 4;
  localparam int F   = 1024;
  localparam int CHW = $clog2(F) - 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           frame_pulse = 1'b0;
  logic [1:0]     rate_sel = '0, adv_code = '0, ref_freq = '0;
  logic           ext_clk_sel = 1'b0;
  logic [7:0]     ch_data;
  logic           data_req, sdo;
  logic [CHW-1:0] req_chan;

  int tests = 0, fails = 0, cycles = 0, fcnt = 0;

  tdm_bit_advancer #(.FRAME_TICKS(F)) i_tdm_bit_advancer (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rate_sel(rate_sel),
    .adv_code(adv_code), .ext_clk_sel(ext_clk_sel), .ref_freq(ref_freq),
    .ch_data(ch_data), .data_req(data_req), .req_chan(req_chan), .sdo(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(int ch);
    return 8'((ch * 29 + 107) ^ (ch << 3));
  endfunction

  always_comb ch_data = pat(int'(req_chan));

  // frame pulse source: one tick in every F
  always @(negedge clk) begin
    if (!rst_n) begin
      fcnt = 0;
      frame_pulse <= 1'b0;
    end else begin
      fcnt = (fcnt + 1) % F;
      frame_pulse <= (fcnt == 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_boundary();
    do @(posedge clk); while (!frame_pulse);
  endtask

  // program settings, let a boundary apply them, compare each tick of that frame
  task automatic run_case(input string tag, input logic [1:0] r, input logic [1:0] lv,
                          input logic ex, input logic [1:0] rf, input int b, input int a,
                          input bit do_mid, input logic [1:0] mid_lv);
    int bad_d = 0, bad_r = 0, fk_d = -1, fk_r = -1;
    logic ad = 1'b0, ed = 1'b0;
    logic [CHW:0] ar = '0, er = '0;
    rate_sel = r; adv_code = lv; ext_clk_sel = ex; ref_freq = rf;
    wait_boundary();
    for (int k = 0; k < F; k++) begin
      int p, ch, bi, nch;
      logic exp_d, exp_q;
      @(negedge clk);
      if (do_mid && k == F/2) adv_code = mid_lv;
      p     = (k + a) % F;
      nch   = F / (8*b);
      ch    = p / (8*b);
      bi    = (p / b) % 8;
      exp_d = pat(ch)[7-bi];
      exp_q = ((p % (8*b)) == 7*b);
      if (sdo !== exp_d) begin
        bad_d++;
        if (fk_d < 0) begin fk_d = k; ad = sdo; ed = exp_d; end
      end
      if (data_req !== exp_q || (exp_q && int'(req_chan) != (ch + 1) % nch)) begin
        bad_r++;
        if (fk_r < 0) begin
          fk_r = k; ar = {data_req, req_chan}; er = {exp_q, CHW'((ch + 1) % nch)};
        end
      end
    end
    tests++;
    if (bad_d != 0) begin
      fails++;
      $display("FAIL %s sdo at tick %0d: actual %b expected %b (%0d bad ticks)", tag, fk_d, ad, ed, bad_d);
    end
    tests++;
    if (bad_r != 0) begin
      fails++;
      $display("FAIL R9 (%s) req at tick %0d: actual %h expected %h", tag, fk_r, ar, er);
    end
  endtask

  task automatic check_reset();
    tests++;
    if (sdo !== 1'b0 || data_req !== 1'b0) begin
      fails++;
      $display("FAIL R2 reset: actual sdo=%b req=%b expected 0 0", sdo, data_req);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    wait_boundary();
    wait_boundary();
    // R1 R2: no advance at each rate
    run_case("R1", 2'd0, 2'd0, 1'b0, 2'd0, 32, 0, 1'b0, 2'd0);
    run_case("R2", 2'd1, 2'd0, 1'b0, 2'd0, 16, 0, 1'b0, 2'd0);
    run_case("R2", 2'd2, 2'd0, 1'b0, 2'd0,  8, 0, 1'b0, 2'd0);
    run_case("R2", 2'd3, 2'd0, 1'b0, 2'd0,  4, 0, 1'b0, 2'd0);
    // R3: internal timebase steps
    run_case("R3", 2'd0, 2'd1, 1'b0, 2'd0, 32, 2, 1'b0, 2'd0);
    run_case("R3", 2'd1, 2'd2, 1'b0, 2'd0, 16, 4, 1'b0, 2'd0);
    run_case("R3", 2'd2, 2'd3, 1'b0, 2'd0,  8, 6, 1'b0, 2'd0);
    run_case("R3", 2'd3, 2'd1, 1'b0, 2'd0,  4, 1, 1'b0, 2'd0);
    run_case("R3", 2'd3, 2'd3, 1'b0, 2'd0,  4, 3, 1'b0, 2'd0);
    // R4: external reference steps
    run_case("R4", 2'd1, 2'd3, 1'b1, 2'd3, 16, 6, 1'b0, 2'd0);
    run_case("R4", 2'd0, 2'd2, 1'b1, 2'd2, 32, 8, 1'b0, 2'd0);
    run_case("R4", 2'd1, 2'd3, 1'b1, 2'd2, 16, 12, 1'b0, 2'd0);
    // R5: slow reference ignores level
    run_case("R5", 2'd2, 2'd3, 1'b1, 2'd1,  8, 0, 1'b0, 2'd0);
    run_case("R5", 2'd0, 2'd3, 1'b1, 2'd0, 32, 0, 1'b0, 2'd0);
    // R6: cap at B-1
    run_case("R6", 2'd2, 2'd3, 1'b1, 2'd2,  8, 7, 1'b0, 2'd0);
    run_case("R6", 2'd3, 2'd2, 1'b1, 2'd2,  4, 3, 1'b0, 2'd0);
    run_case("R6", 2'd3, 2'd3, 1'b1, 2'd3,  4, 3, 1'b0, 2'd0);
    // R7: level changed mid-frame leaves this frame alone
    run_case("R7", 2'd2, 2'd1, 1'b0, 2'd0,  8, 2, 1'b1, 2'd3);
    // R8: wrap of the advanced grid across the boundary
    run_case("R8", 2'd0, 2'd3, 1'b0, 2'd0, 32, 6, 1'b0, 2'd0);
    run_case("R8", 2'd2, 2'd2, 1'b0, 2'd0,  8, 4, 1'b0, 2'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule